// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block sits beside one UART channel and decides which way an external half-duplex line driver points. It watches the transmit side: the transmit FIFO empty flag and the busy flag of the transmit shift register. From these it drives a direction pin whose level for "transmitting" can be inverted by a polarity control. When automatic direction control is turned off, the pin simply carries the flow-control or general-purpose value supplied by the surrounding logic.

The block also gates the two data paths of the channel. A transmitter disable withholds permission to load the shift register, and it holds the TX pin at mark once the character already shifting has gone out. The FIFO in front of the shift register is not touched and keeps taking writes. A receiver disable refuses any new character at once. A character whose start was already accepted is still allowed to write into the receive FIFO when it completes.

All outputs are registered and the block uses a synchronous, active-high reset.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `dir_out`=1, `tsr_load_ok`=1, `rxf_wr_ok`=0 and `tx_mark_hold`=0. The internal transmit-activity and accepted-character states are cleared.
- R2: With `cfg_auto_dir`=0, `dir_out` equals the `rts_fc` value sampled at the previous clock edge. `cfg_pol_inv` has no effect in this case.
- R3: With `cfg_auto_dir`=1 and `cfg_pol_inv`=0, `dir_out` is 0 while in the transmit state and 1 otherwise.
- R4: With `cfg_auto_dir`=1 and `cfg_pol_inv`=1, `dir_out` is 1 while in the transmit state and 0 otherwise.
- R5: The transmit state begins at the first edge that samples `tsr_busy`=1. It persists across gaps with `tsr_busy`=0 as long as `txf_empty`=0. It ends at the edge that samples `tsr_busy`=0 together with `txf_empty`=1, so `dir_out` returns to the receive level one clock after the last stop bit.
- R6: `tsr_load_ok` is the inverse of `cfg_tx_off` as sampled at the previous edge. While `cfg_tx_off`=1, the transmit state ends as soon as `tsr_busy` is sampled 0, even if `txf_empty`=0.
- R7: `tx_mark_hold` is 1 exactly when the previous edge sampled `cfg_tx_off`=1 and `tsr_busy`=0. This means the TX pin is held at mark only after any in-flight character has finished.
- R8: An `rx_start` pulse sampled while `cfg_rx_off`=0 sets `rxf_wr_ok` to 1 from the next cycle. It stays 1 through the cycle in which `rx_done` is high and clears at the edge that samples `rx_done`=1.
- R9: An `rx_start` sampled while `cfg_rx_off`=1 leaves `rxf_wr_ok` at 0. Raising `cfg_rx_off` while `rxf_wr_ok`=1 does not clear it before `rx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_auto_dir | input | 1 | 1 = direction pin driven from transmit activity |
| cfg_pol_inv | input | 1 | 1 = transmit state drives the pin high |
| cfg_tx_off | input | 1 | Transmitter disable |
| cfg_rx_off | input | 1 | Receiver disable |
| rts_fc | input | 1 | Flow-control / general-purpose pin value used when auto direction is off |
| txf_empty | input | 1 | Transmit FIFO empty flag |
| tsr_busy | input | 1 | Transmit shift register is sending a character |
| rx_start | input | 1 | Receiver detected a start bit (one-cycle strobe) |
| rx_done | input | 1 | Receiver finished a character (one-cycle strobe) |
| dir_out | output | 1 | Direction / RTS pin level |
| tsr_load_ok | output | 1 | Permission to load the transmit shift register |
| rxf_wr_ok | output | 1 | Permission to write the finished character into the receive FIFO |
| tx_mark_hold | output | 1 | Force the TX pin to mark (1) |

## Verification
A wrong transmit-activity state appears on `dir_out` within one clock when automatic direction is on. The clearest cases are a direction drop during the gap between two characters while the FIFO still holds data, or a late release after the last stop bit. A wrong accepted-character flag appears on `rxf_wr_ok` one clock after `rx_start`, or fails to clear one clock after `rx_done`. The vectors therefore pair every state transition with an output sample one edge later. Polarity swaps, FIFO gaps and disables raised in mid-character make the off-by-one and inversion faults visible.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic {
    SIDE_RX = 1'b0,
    SIDE_TX = 1'b1
  } line_side_e;

  localparam logic MARK_LVL   = 1'b1;
  localparam logic RST_DIR_LV = 1'b1;

  // Pin level for a given side: with no inversion the transmit side is low.
  function automatic logic side_level(line_side_e side, logic inv);
    return (side == SIDE_TX) ? inv : ~inv;
  endfunction

endpackage

// File: rtl/rs485_tx_track.sv
module rs485_tx_track
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_tx_off,
  input  logic       txf_empty,
  input  logic       tsr_busy,
  output line_side_e side_nxt,
  output logic       tsr_load_ok,
  output logic       tx_mark_hold
);

  logic tx_act_q;
  logic act_nxt;

  // Activity holds across inter-character gaps while data is still queued
  // and the transmitter is enabled.
  assign act_nxt  = tsr_busy | (tx_act_q & ~txf_empty & ~cfg_tx_off);
  assign side_nxt = act_nxt ? SIDE_TX : SIDE_RX;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_act_q     <= 1'b0;
      tsr_load_ok  <= 1'b1;
      tx_mark_hold <= 1'b0;
    end else begin
      tx_act_q     <= act_nxt;
      tsr_load_ok  <= ~cfg_tx_off;
      tx_mark_hold <= cfg_tx_off & ~tsr_busy;
    end
  end

  // R5
  busy_enters_tx_chk: assert property (@(posedge clk) disable iff (rst)
    tsr_busy |=> tx_act_q);

  // R5
  drained_leaves_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (!tsr_busy && txf_empty) |=> !tx_act_q);

  // R6
  load_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_tx_off |=> !tsr_load_ok);

  // R7
  no_mark_midchar_chk: assert property (@(posedge clk) disable iff (rst)
    tsr_busy |=> !tx_mark_hold);

endmodule

// File: rtl/rs485_rx_gate.sv
module rs485_rx_gate (
  input  logic clk,
  input  logic rst,
  input  logic cfg_rx_off,
  input  logic rx_start,
  input  logic rx_done,
  output logic rxf_wr_ok
);

  logic accept;

  assign accept = rx_start & ~cfg_rx_off;

  always_ff @(posedge clk) begin
    if (rst)         rxf_wr_ok <= 1'b0;
    else if (accept) rxf_wr_ok <= 1'b1;
    else if (rx_done) rxf_wr_ok <= 1'b0;
  end

  // R8
  start_accepted_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_start && !cfg_rx_off) |=> rxf_wr_ok);

  // R9
  start_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (!rxf_wr_ok && cfg_rx_off) |=> !rxf_wr_ok);

  // R9
  inflight_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (rxf_wr_ok && !rx_done) |=> rxf_wr_ok);

endmodule

// File: rtl/rs485_dir_mux.sv
module rs485_dir_mux
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_auto_dir,
  input  logic       cfg_pol_inv,
  input  logic       rts_fc,
  input  line_side_e side_nxt,
  output logic       dir_out
);

  logic lvl_nxt;

  assign lvl_nxt = cfg_auto_dir ? side_level(side_nxt, cfg_pol_inv) : rts_fc;

  always_ff @(posedge clk) begin
    if (rst) dir_out <= RST_DIR_LV;
    else     dir_out <= lvl_nxt;
  end

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_auto_dir |=> (dir_out == $past(rts_fc)));

  // R3
  tx_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_auto_dir && !cfg_pol_inv && side_nxt == SIDE_TX) |=> !dir_out);

  // R4
  tx_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_auto_dir && cfg_pol_inv && side_nxt == SIDE_TX) |=> dir_out);

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cfg_auto_dir,
  input  logic cfg_pol_inv,
  input  logic cfg_tx_off,
  input  logic cfg_rx_off,
  input  logic rts_fc,
  input  logic txf_empty,
  input  logic tsr_busy,
  input  logic rx_start,
  input  logic rx_done,
  output logic dir_out,
  output logic tsr_load_ok,
  output logic rxf_wr_ok,
  output logic tx_mark_hold
);

  line_side_e side_nxt;

  rs485_tx_track u_tx (
    .clk          (clk),
    .rst          (rst),
    .cfg_tx_off   (cfg_tx_off),
    .txf_empty    (txf_empty),
    .tsr_busy     (tsr_busy),
    .side_nxt     (side_nxt),
    .tsr_load_ok  (tsr_load_ok),
    .tx_mark_hold (tx_mark_hold)
  );

  rs485_rx_gate u_rx (
    .clk        (clk),
    .rst        (rst),
    .cfg_rx_off (cfg_rx_off),
    .rx_start   (rx_start),
    .rx_done    (rx_done),
    .rxf_wr_ok  (rxf_wr_ok)
  );

  rs485_dir_mux u_dir (
    .clk          (clk),
    .rst          (rst),
    .cfg_auto_dir (cfg_auto_dir),
    .cfg_pol_inv  (cfg_pol_inv),
    .rts_fc       (rts_fc),
    .side_nxt     (side_nxt),
    .dir_out      (dir_out)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (dir_out && tsr_load_ok && !rxf_wr_ok && !tx_mark_hold));

endmodule

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst;
  logic cfg_auto_dir, cfg_pol_inv, cfg_tx_off, cfg_rx_off, rts_fc;
  logic txf_empty, tsr_busy, rx_start, rx_done;
  logic dir_out, tsr_load_ok, rxf_wr_ok, tx_mark_hold;

  int errors = 0;
  int checks = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  rs485_dir_ctrl dut_i (
    .clk(clk), .rst(rst),
    .cfg_auto_dir(cfg_auto_dir), .cfg_pol_inv(cfg_pol_inv),
    .cfg_tx_off(cfg_tx_off), .cfg_rx_off(cfg_rx_off), .rts_fc(rts_fc),
    .txf_empty(txf_empty), .tsr_busy(tsr_busy),
    .rx_start(rx_start), .rx_done(rx_done),
    .dir_out(dir_out), .tsr_load_ok(tsr_load_ok),
    .rxf_wr_ok(rxf_wr_ok), .tx_mark_hold(tx_mark_hold)
  );

  // Stimulus [12:4] = auto,pol,txoff,rxoff,rts,txfe,busy,rxs,rxd
  // Expected [3:0]  = dir,load,wr,mark (after one edge)
  localparam int NV = 15;
  localparam logic [12:0] VEC [NV] = '{
    13'b0_0_0_0_0_1_0_0_0_0100,  // R2 rts 0 passes through
    13'b0_1_0_0_1_1_0_0_0_1100,  // R2 pol ignored, rts 1
    13'b1_0_0_0_0_1_0_0_0_1100,  // R3 idle, receive high
    13'b1_0_0_0_0_0_1_0_0_0100,  // R3 busy -> transmit low
    13'b1_0_0_0_0_0_0_0_0_0100,  // R5 gap with data queued holds
    13'b1_0_0_0_0_1_0_0_0_1100,  // R5 drained -> receive
    13'b1_1_0_0_0_1_1_0_0_1100,  // R4 inverted transmit high
    13'b1_1_0_0_0_1_0_0_0_0100,  // R4 inverted receive low
    13'b1_1_0_0_0_1_0_1_0_0110,  // R8 accepted start
    13'b1_1_0_1_0_1_0_0_0_0110,  // R9 disable mid-char keeps permit
    13'b1_1_0_1_0_1_0_0_1_0100,  // R8 done clears
    13'b1_1_0_1_0_1_0_1_0_0100,  // R9 start refused while off
    13'b1_1_1_0_0_0_1_0_0_1000,  // R6 load blocked, char in flight
    13'b1_1_1_0_0_0_0_0_0_0001,  // R7 mark held; R6 tx state ends
    13'b1_1_0_0_0_1_0_0_0_0100   // R6 re-enabled
  };

  function automatic string vtag(int i);
    case (i)
      0, 1:       return "R2";
      2, 3:       return "R3";
      4, 5:       return "R5";
      6, 7:       return "R4";
      8, 10:      return "R8";
      9, 11:      return "R9";
      13:         return "R7";
      default:    return "R6";
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {dir,load,wr,mark} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(logic [8:0] s);
    {cfg_auto_dir, cfg_pol_inv, cfg_tx_off, cfg_rx_off, rts_fc,
     txf_empty, tsr_busy, rx_start, rx_done} = s;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [3:0] outs();
    return {dir_out, tsr_load_ok, rxf_wr_ok, tx_mark_hold};
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    apply(9'b0_0_0_0_0_1_0_0_0);
    @(negedge clk);
    step();
    chk("R1", outs(), 4'b1100);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][12:4]);
      step();
      chk(vtag(i), outs(), VEC[i][3:0]);
    end

    // R5: multi-character burst, direction held until last stop bit ends
    apply(9'b1_0_0_0_0_0_1_0_0);
    step(); chk("R5", outs(), 4'b0100);
    apply(9'b1_0_0_0_0_0_0_0_0);
    step(); chk("R5", outs(), 4'b0100);
    apply(9'b1_0_0_0_0_1_1_0_0);
    step(); chk("R5", outs(), 4'b0100);
    step(); chk("R5", outs(), 4'b0100);
    apply(9'b1_0_0_0_0_1_0_0_0);
    step(); chk("R5", outs(), 4'b1100);

    // R9: start in the same cycle the receiver is disabled is refused
    apply(9'b1_0_0_1_0_1_0_1_0);
    step(); chk("R9", outs(), 4'b1100);

    // R8: permit persists for a full character until done
    apply(9'b1_0_0_0_0_1_0_1_0);
    step(); chk("R8", outs(), 4'b1110);
    apply(9'b1_0_0_0_0_1_0_0_0);
    step(); chk("R8", outs(), 4'b1110);
    step(); chk("R8", outs(), 4'b1110);
    apply(9'b1_0_0_0_0_1_0_0_1);
    step(); chk("R8", outs(), 4'b1100);

    // R1: reset mid-activity clears transmit state and receive permit
    apply(9'b1_1_1_0_0_0_1_1_0);
    step(); chk("R4", outs(), 4'b1010);
    rst = 1'b1;
    step(); chk("R1", outs(), 4'b1100);
    rst = 1'b0;
    apply(9'b1_0_0_0_0_1_0_0_0);
    step(); chk("R1", outs(), 4'b1100);

    finish_run();
  end

endmodule